// File: doc/BRIEF.md
# Polar Constituent-Node Decoder

This block decodes a single constituent node of a simplified successive-cancellation polar decoding tree. It takes a node of `NV` soft values, each a 16-bit two's-complement log-likelihood ratio, together with a 3-bit node kind. It returns two vectors. The first is the node's hard-decision vector (beta) after any kind-specific correction. The second is the codeword-domain bit vector obtained by putting beta through the polar transform. Four shortcut kinds are handled: all frozen, all information, repetition and single parity check. Every other code value, and in particular a pruned node whose frozen pattern matches none of the four kinds, is decoded by plain hard decision followed by the transform.

The node enters on a valid/ready stream and leaves on a second valid/ready stream. A node is taken when `in_valid` and `in_ready` are both high at a rising clock edge. A result is handed over when `out_valid` and `out_ready` are both high. The downstream side may hold `out_ready` low for as long as it likes. The result then stays put and the pipeline fills. Once the internal stage and the output register are both full, `in_ready` drops. The upstream side must keep `in_valid` and its data steady until the transfer happens. The block has two register stages, so a node accepted at edge E is presented at the output from edge E+1 onward. With `out_ready` held high it takes one node per cycle.

Top module: `psd_node_decoder`

## Requirements
- R1: Soft value i sits in `in_llr[16*i+15:16*i]`, and bit i of `out_beta` and `out_code` belongs to it. The hard decision is 0 for a value of zero or above and 1 for a negative value. For kind code 1 (all information), `out_beta` is the hard-decision vector.
- R2: For kind code 0 (all frozen), `out_beta` and `out_code` are all zeros whatever the soft values are.
- R3: For kind code 2 (repetition, only index NV-1 carries information), all NV values are summed in an accumulator wide enough that the sum cannot overflow. The decision d is 1 when the sum is negative and 0 otherwise, including a sum of exactly zero. `out_beta` is d in every bit, and `out_code` has d at bit NV-1 and zeros elsewhere.
- R4: For kind code 3 (single parity check, index 0 frozen), the block first takes hard decisions. If their parity is odd, it inverts the bit whose value has the smallest magnitude. When several magnitudes tie, the lowest index is inverted. `out_beta` then always has even parity and `out_code[0]` is 0.
- R5: Kind code 4 (pruned node with no special pattern) and the unused codes 5 to 7 are decoded as plain hard decision followed by the transform.
- R6: For every kind, `out_code[j]` is the XOR of `out_beta[i]` over every i whose binary digits include all the binary digits of j (that is, `i & j == j`).
- R7: A node accepted at edge E is presented with `out_valid` high from edge E+1 onward. While `out_valid` is high and `out_ready` is low, the outputs hold steady. With both stages full, `in_ready` is low. While `out_valid` is low, `in_ready` is high.
- R8: During and right after reset, `out_valid` is low and `in_ready` is high.
- R9: With `out_ready` held high, nodes offered on consecutive cycles are accepted on consecutive cycles and come out in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Node offered |
| in_ready | output | 1 | Node can be taken this cycle |
| in_kind | input | 3 | Node kind code (0 frozen, 1 information, 2 repetition, 3 parity, 4 to 7 hard decision) |
| in_llr | input | NV*16 | Soft values, index i at bits 16*i+15 down to 16*i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_beta | output | NV | Corrected hard-decision vector |
| out_code | output | NV | Polar-transformed vector |

## Verification
A wrong internal state here shows as a wrong bit pattern on the same output beat that carries the affected node, two edges after it was taken, so each fault is caught on the node that caused it. A wrong minimum index in the parity path leaves `out_beta` with even parity but flips the wrong bit. That is visible only against a reference on tie and zero-magnitude vectors. A narrow repetition accumulator shows up on full-scale negative vectors as a sign flip in `out_code[NV-1]`. A broken hold path shows as `out_beta` or `out_code` changing while `out_ready` is low, on the very next edge.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned LLR_W = 16;

  typedef enum logic [2:0] {
    NK_FROZEN = 3'd0,
    NK_INFO   = 3'd1,
    NK_REP    = 3'd2,
    NK_SPC    = 3'd3,
    NK_HARD   = 3'd4
  } node_kind_e;
endpackage

// File: rtl/psd_stats.sv
// Per-node statistics: sign decisions, widened sum sign, least-reliable index.
module psd_stats #(
  parameter int unsigned NV    = 16,
  parameter int unsigned LLR_W = 16
) (
  input  logic [NV*LLR_W-1:0]    llr,
  output logic [NV-1:0]          hard,
  output logic                   rep_bit,
  output logic [$clog2(NV)-1:0]  min_idx
);
  localparam int unsigned IW    = $clog2(NV);
  localparam int unsigned SW    = LLR_W + IW;
  localparam int unsigned NODES = 2 * NV - 1;

  logic signed [SW-1:0] acc;
  logic [LLR_W-1:0] t_mag [NODES];
  logic [IW-1:0]    t_idx [NODES];

  // sign decisions and magnitudes at the tree leaves
  for (genvar i = 0; i < NV; i++) begin : g_leaf
    logic [LLR_W-1:0] v;
    assign v = llr[i*LLR_W +: LLR_W];
    assign hard[i] = v[LLR_W-1];
    assign t_mag[NV-1+i] = v[LLR_W-1] ? (~v + 1'b1) : v;
    assign t_idx[NV-1+i] = IW'(i);
  end

  // comparison tree, left (lower index) wins a tie
  for (genvar k = 0; k < NV - 1; k++) begin : g_node
    logic take_left;
    assign take_left = t_mag[2*k+1] <= t_mag[2*k+2];
    assign t_mag[k]  = take_left ? t_mag[2*k+1] : t_mag[2*k+2];
    assign t_idx[k]  = take_left ? t_idx[2*k+1] : t_idx[2*k+2];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NV; i++) begin
      acc = acc + SW'(signed'(llr[i*LLR_W +: LLR_W]));
    end
  end

  assign rep_bit = acc[SW-1];
  assign min_idx = t_idx[0];
endmodule

// File: rtl/psd_select.sv
// Builds the node's corrected beta vector from the statistics and kind.
module psd_select
  import psd_pkg::*;
#(
  parameter int unsigned NV = 16
) (
  input  logic [2:0]            kind,
  input  logic [NV-1:0]         hard,
  input  logic                  rep_bit,
  input  logic [$clog2(NV)-1:0] min_idx,
  output logic [NV-1:0]         beta
);
  logic          odd;
  logic [NV-1:0] flip;

  assign odd = ^hard;

  always_comb begin
    flip = '0;
    flip[min_idx] = odd;
  end

  always_comb begin
    case (kind)
      NK_FROZEN: beta = '0;
      NK_REP:    beta = {NV{rep_bit}};
      NK_SPC:    beta = hard ^ flip;
      default:   beta = hard;
    endcase
  end
endmodule

// File: rtl/psd_xform.sv
// Polar transform x = u*G as log2(NV) XOR butterfly stages.
module psd_xform #(
  parameter int unsigned NV = 16
) (
  input  logic [NV-1:0] u,
  output logic [NV-1:0] x
);
  localparam int unsigned ST = $clog2(NV);

  logic [NV-1:0] lvl [ST+1];
  assign lvl[0] = u;

  for (genvar s = 0; s < ST; s++) begin : g_stage
    for (genvar i = 0; i < NV; i++) begin : g_bit
      if (((i >> s) & 1) == 0) begin : g_mix
        assign lvl[s+1][i] = lvl[s][i] ^ lvl[s][i + (1 << s)];
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign x = lvl[ST];
endmodule

// File: rtl/psd_node_decoder.sv
module psd_node_decoder
  import psd_pkg::*;
#(
  parameter int unsigned NV = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_kind,
  input  logic [NV*LLR_W-1:0]  in_llr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NV-1:0]        out_beta,
  output logic [NV-1:0]        out_code
);
  localparam int unsigned IW = $clog2(NV);

  // stage 1: statistics
  logic [NV-1:0] st_hard;
  logic          st_rep;
  logic [IW-1:0] st_min;

  psd_stats #(.NV(NV), .LLR_W(LLR_W)) u_stats (
    .llr(in_llr), .hard(st_hard), .rep_bit(st_rep), .min_idx(st_min)
  );

  logic          s1_valid;
  logic [2:0]    s1_kind;
  logic [NV-1:0] s1_hard;
  logic          s1_rep;
  logic [IW-1:0] s1_min;
  logic          s2_ready;

  assign s2_ready = !out_valid || out_ready;
  assign in_ready = !s1_valid || s2_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_kind  <= '0;
      s1_hard  <= '0;
      s1_rep   <= 1'b0;
      s1_min   <= '0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_kind <= in_kind;
        s1_hard <= st_hard;
        s1_rep  <= st_rep;
        s1_min  <= st_min;
      end
    end
  end

  // stage 2: correction and transform
  logic [NV-1:0] sel_beta;
  logic [NV-1:0] sel_code;
  logic [2:0]    q_kind;

  psd_select #(.NV(NV)) u_select (
    .kind(s1_kind), .hard(s1_hard), .rep_bit(s1_rep), .min_idx(s1_min),
    .beta(sel_beta)
  );

  psd_xform #(.NV(NV)) u_xform (
    .u(sel_beta), .x(sel_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beta  <= '0;
      out_code  <= '0;
      q_kind    <= '0;
    end else if (s2_ready) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_beta <= sel_beta;
        out_code <= sel_code;
        q_kind   <= s1_kind;
      end
    end
  end
endmodule

// File: rtl/psd_node_decoder_chk.sv
module psd_node_decoder_chk
  import psd_pkg::*;
#(
  parameter int unsigned NV = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [NV-1:0] out_beta,
  input logic [NV-1:0] out_code,
  input logic [2:0]    cur_kind
);
  // R7: stall holds the result
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_beta) && $stable(out_code));

  // R7: empty output slot implies input side open
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2: frozen node is all zero
  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cur_kind == NK_FROZEN |-> out_beta == '0 && out_code == '0);

  // R3: repetition node repeats one decision, code carries it only at top index
  p_rep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cur_kind == NK_REP |->
      (out_beta == '0 || out_beta == '1) && out_code[NV-2:0] == '0
      && out_code[NV-1] == out_beta[0]);

  // R4: parity node leaves even parity and a zero frozen bit
  p_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cur_kind == NK_SPC |-> !(^out_beta) && !out_code[0]);
endmodule

bind psd_node_decoder psd_node_decoder_chk #(.NV(NV)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_beta(out_beta), .out_code(out_code),
  .cur_kind(q_kind)
);

// File: tb/psd_node_decoder_test.sv
`timescale 1ns/1ps
module psd_node_decoder_test;
  localparam int NV = 16;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_kind = '0;
  logic [NV*W-1:0] in_llr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NV-1:0] out_beta, out_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psd_node_decoder #(.NV(NV)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_llr(in_llr), .out_valid(out_valid),
    .out_ready(out_ready), .out_beta(out_beta), .out_code(out_code)
  );

  task automatic check(input string tag, input logic [NV-1:0] act, input logic [NV-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- reference model ----------
  function automatic logic [NV-1:0] ref_xform(input logic [NV-1:0] b);
    logic [NV-1:0] x = '0;
    for (int j = 0; j < NV; j++)
      for (int i = 0; i < NV; i++)
        if ((i & j) == j) x[j] = x[j] ^ b[i];
    return x;
  endfunction

  function automatic logic [NV-1:0] ref_beta(input logic [2:0] k, input logic [NV*W-1:0] l);
    logic [NV-1:0] h;
    longint sum = 0;
    int best = 0;
    int bmag = 70000;
    for (int i = 0; i < NV; i++) begin
      int v = int'($signed(l[i*W +: W]));
      int m = (v < 0) ? -v : v;
      h[i] = (v < 0);
      sum += v;
      if (m < bmag) begin bmag = m; best = i; end
    end
    case (k)
      3'd0: return '0;
      3'd2: return (sum < 0) ? '1 : '0;
      3'd3: begin
        if (^h) h[best] = ~h[best];
        return h;
      end
      default: return h;
    endcase
  endfunction

  function automatic logic [NV*W-1:0] rnd_llr();
    logic [NV*W-1:0] r;
    for (int i = 0; i < NV; i++) begin
      case ($urandom % 6)
        0: r[i*W +: W] = 16'h0000;
        1: r[i*W +: W] = 16'h8000;
        2: r[i*W +: W] = 16'h7fff;
        default: r[i*W +: W] = 16'($urandom);
      endcase
    end
    return r;
  endfunction

  // ---------- drivers ----------
  task automatic push(input logic [2:0] k, input logic [NV*W-1:0] l);
    in_valid = 1'b1; in_kind = k; in_llr = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull(input string tag, input logic [2:0] k, input logic [NV*W-1:0] l);
    logic [NV-1:0] eb;
    while (!out_valid) @(negedge clk);
    eb = ref_beta(k, l);
    check({tag, " beta"}, out_beta, eb);
    check({tag, " code (R6)"}, out_code, ref_xform(eb));
    @(negedge clk);
  endtask

  task automatic one(input string tag, input logic [2:0] k, input logic [NV*W-1:0] l);
    push(k, l);
    pull(tag, k, l);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    check("R8 out_valid after reset", NV'(out_valid), NV'(0));
    check("R8 in_ready after reset", NV'(in_ready), NV'(1));
  endtask

  task automatic t_frozen();
    logic [NV*W-1:0] l = '1;
    one("R2 frozen all-negative", 3'd0, l);
    for (int n = 0; n < 3; n++) one("R2 frozen random", 3'd0, rnd_llr());
  endtask

  task automatic t_info();
    logic [NV*W-1:0] l = '0;
    l[5*W +: W] = 16'h8000;
    l[9*W +: W] = 16'hffff;
    one("R1 info sign rule", 3'd1, l);
    for (int n = 0; n < 4; n++) one("R1 info random", 3'd1, rnd_llr());
  endtask

  task automatic t_rep();
    logic [NV*W-1:0] l;
    for (int i = 0; i < NV; i++) l[i*W +: W] = 16'h8000;
    one("R3 rep full-scale negative sum", 3'd2, l);
    for (int i = 0; i < NV; i++) l[i*W +: W] = 16'h7fff;
    one("R3 rep full-scale positive sum", 3'd2, l);
    l = '0;
    l[0 +: W] = 16'd5;
    l[W +: W] = -16'sd5;
    one("R3 rep zero sum decides 0", 3'd2, l);
    for (int n = 0; n < 4; n++) one("R3 rep random", 3'd2, rnd_llr());
  endtask

  task automatic t_spc();
    logic [NV*W-1:0] l;
    for (int i = 0; i < NV; i++) l[i*W +: W] = 16'd100;
    l[3*W +: W] = -16'sd7;
    l[9*W +: W] = 16'd7;
    one("R4 spc tie flips lowest index", 3'd3, l);
    for (int i = 0; i < NV; i++) l[i*W +: W] = 16'd300;
    l[6*W +: W] = 16'h8000;
    l[11*W +: W] = 16'd0;
    l[13*W +: W] = 16'd0;
    one("R4 spc zero magnitude flip", 3'd3, l);
    l[6*W +: W] = 16'd300;
    l[2*W +: W] = -16'sd4;
    l[4*W +: W] = -16'sd4;
    one("R4 spc even parity untouched", 3'd3, l);
    for (int n = 0; n < 6; n++) one("R4 spc random", 3'd3, rnd_llr());
  endtask

  task automatic t_hard();
    for (int k = 4; k < 8; k++) one("R5 hard-decision fallback", 3'(k), rnd_llr());
  endtask

  task automatic t_latency();
    logic [NV*W-1:0] l = rnd_llr();
    push(3'd1, l);
    check("R7 not yet valid one edge after accept", NV'(out_valid), NV'(0));
    @(negedge clk);
    check("R7 valid two edges after accept", NV'(out_valid), NV'(1));
    pull("R7 latency data", 3'd1, l);
  endtask

  task automatic t_stall();
    logic [NV*W-1:0] a = rnd_llr(), b = rnd_llr(), c = rnd_llr();
    logic [NV-1:0] held;
    out_ready = 1'b0;
    push(3'd3, a);
    push(3'd1, b);
    check("R7 in_ready low when full", NV'(in_ready), NV'(0));
    held = out_beta;
    repeat (3) @(negedge clk);
    check("R7 output held during stall", out_beta, held);
    check("R7 stall valid kept", NV'(out_valid), NV'(1));
    out_ready = 1'b1;
    fork
      push(3'd2, c);
      begin
        pull("R7 stalled first", 3'd3, a);
        pull("R7 stalled second", 3'd1, b);
        pull("R7 stalled third", 3'd2, c);
      end
    join
  endtask

  task automatic t_stream();
    logic [NV*W-1:0] v [8];
    logic [2:0] kk [8];
    int acc_cnt = 0;
    for (int i = 0; i < 8; i++) begin v[i] = rnd_llr(); kk[i] = 3'(i % 5); end
    fork
      begin
        in_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
          in_kind = kk[i]; in_llr = v[i];
          if (in_ready) acc_cnt++;
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin
        @(negedge clk);
        for (int i = 0; i < 8; i++) pull("R9 back-to-back", kk[i], v[i]);
      end
    join
    check("R9 accepted every cycle", NV'(acc_cnt), NV'(8));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frozen();
    t_info();
    t_rep();
    t_spc();
    t_hard();
    t_latency();
    t_stall();
    t_stream();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule